// File: doc/BRIEF.md
# Maskable Time-of-Day Alarm

This block compares a programmed alarm time against the running BCD time of a real-time clock. The time arrives from an external counter set as four BCD bytes: seconds, minutes, hours and date of month. A one-cycle seconds strobe accompanies each update. On every strobe, the block checks each alarm field whose mask bit is clear against the live time. If every checked field agrees, it latches an alarm flag. An active-low interrupt output follows the flag, gated by two enables.

A host reaches four alarm bytes and one control/status byte through a small synchronous register port. The mask bits give a choice of repeat rate: once a month on a set date, daily, hourly, every minute, or every second. The first enable gates the interrupt while main power is present. When the mode input reports battery-backed operation, the interrupt needs both enables. A power-up strobe clears both enables, but a match during that strobe still sets the flag. Software can therefore see that an alarm happened while power was returning.

Top module: `tod_alarm`

## Requirements
- R1: Synchronous reset clears all alarm bytes, both enables and the flag, drives `irq_n` high and drives `bus_rdata` to zero.
- R2: Writes to offsets 2 (seconds), 3 (minutes), 4 (hours) and 5 (date) store all eight bits. A read with `bus_rd` presents the stored byte on `bus_rdata` after the next clock edge. Offsets 0, 1 and 7 read as zero.
- R3: On a cycle with `tick` high, the flag is set when every alarm byte whose bit 7 is 0 matches the live value for that field. A field matches when its bits 6:0 equal the live byte and the live bit 7 is 0. If any checked field differs, the flag is left unchanged.
- R4: Alarm bytes with bit 7 set are left out of the comparison. With all four masked, every tick sets the flag. With only the date masked, a match needs hours, minutes and seconds to agree (daily repeat).
- R5: Without `tick`, the flag is never set, even when the live time equals the alarm.
- R6: The control byte sits at offset 6. It reads as bit 7 = AE (enable under main power), bit 6 = ABE (enable under battery) and bit 0 = flag, with all other bits 0. A write loads AE and ABE from bits 7 and 6 and does not change the flag.
- R7: With `on_battery` low, `irq_n` is low exactly when the flag and AE are both set. It goes low on the clock edge after the edge that sets the flag.
- R8: With `on_battery` high, `irq_n` goes low only when the flag, AE and ABE are all set.
- R9: Reading offset 6 returns the flag and then clears it, so `irq_n` returns high one edge later.
- R10: `power_up` clears AE and ABE, and takes priority over a host write in the same cycle. A match in that same cycle still sets the flag.
- R11: If a matching tick and a read of offset 6 fall in the same cycle, the flag stays set. The read returns the flag value from before that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick | input | 1 | One-cycle strobe marking a seconds update |
| cur_sec | input | 8 | Live seconds, BCD |
| cur_min | input | 8 | Live minutes, BCD |
| cur_hour | input | 8 | Live hours (24-hour), BCD |
| cur_date | input | 8 | Live date of month, BCD |
| on_battery | input | 1 | High while running from the backup source |
| power_up | input | 1 | Strobe marking the return of main power |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe |
| bus_addr | input | ADDR_W | Register offset |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Registered read data |
| irq_n | output | 1 | Active-low alarm interrupt, registered |

## Verification
The risky coincidence is a seconds strobe that matches the alarm in the same cycle as a host read of the control byte. The flag then receives a set and a clear at once. The bench drives `tick` with a matching time and a read of offset 6 on the same clock edge. It expects the read to return the old flag and a second read to return the flag as set. A power-up strobe paired with a matching tick is judged in the same way: both enables must read back as zero while the flag reads as one.

// File: rtl/tod_alarm_pkg.sv
package tod_alarm_pkg;
  localparam int unsigned BYTE_W     = 8;
  localparam int unsigned NUM_FIELDS = 4;   // 0 sec, 1 min, 2 hour, 3 date
  localparam int unsigned OFS_FIRST  = 2;   // offset of the seconds alarm byte
  localparam int unsigned OFS_CTRL   = 6;
  localparam int unsigned MASK_BIT   = 7;
  localparam int unsigned AE_BIT     = 7;
  localparam int unsigned ABE_BIT    = 6;
  localparam int unsigned AF_BIT     = 0;

  typedef logic [NUM_FIELDS-1:0][BYTE_W-1:0] field_vec_t;
endpackage

// File: rtl/tod_alarm_regs.sv
module tod_alarm_regs
  import tod_alarm_pkg::*;
#(
  parameter int unsigned ADDR_W = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr,
  input  logic [ADDR_W-1:0] addr,
  input  logic [BYTE_W-1:0] wdata,
  output field_vec_t        alarm_bytes
);
  for (genvar g = 0; g < NUM_FIELDS; g++) begin : g_field
    localparam logic [ADDR_W-1:0] MY_OFS = ADDR_W'(OFS_FIRST + g);
    always_ff @(posedge clk) begin
      if (rst)                      alarm_bytes[g] <= '0;
      else if (wr && addr == MY_OFS) alarm_bytes[g] <= wdata;
    end

    assert_write_lands_R2: assert property (@(posedge clk) disable iff (rst)
      (wr && addr == MY_OFS) |=> alarm_bytes[g] == $past(wdata));
  end
endmodule

// File: rtl/tod_alarm_match.sv
module tod_alarm_match
  import tod_alarm_pkg::*;
(
  input  logic       tick,
  input  field_vec_t alarm_bytes,
  input  field_vec_t live,
  output logic       hit
);
  logic [NUM_FIELDS-1:0] field_ok;

  for (genvar g = 0; g < NUM_FIELDS; g++) begin : g_cmp
    always_comb begin
      field_ok[g] = alarm_bytes[g][MASK_BIT] ||
                    ({1'b0, alarm_bytes[g][MASK_BIT-1:0]} == live[g]);
    end
  end

  always_comb hit = tick && (&field_ok);
endmodule

// File: rtl/tod_alarm_flag.sv
module tod_alarm_flag (
  input  logic clk,
  input  logic rst,
  input  logic hit,
  input  logic rd_ctrl,
  input  logic wr_ctrl,
  input  logic wdata_ae,
  input  logic wdata_abe,
  input  logic power_up,
  input  logic on_battery,
  output logic ae,
  output logic abe,
  output logic af,
  output logic irq_n
);
  always_ff @(posedge clk) begin
    if (rst) begin
      ae  <= 1'b0;
      abe <= 1'b0;
    end else if (power_up) begin
      ae  <= 1'b0;
      abe <= 1'b0;
    end else if (wr_ctrl) begin
      ae  <= wdata_ae;
      abe <= wdata_abe;
    end
  end

  always_ff @(posedge clk) begin
    if (rst)          af <= 1'b0;
    else if (hit)     af <= 1'b1;
    else if (rd_ctrl) af <= 1'b0;
  end

  always_ff @(posedge clk) begin
    if (rst) irq_n <= 1'b1;
    else     irq_n <= !(af && ae && (!on_battery || abe));
  end

  assert_flag_source_R3: assert property (@(posedge clk) disable iff (rst)
    $rose(af) |-> $past(hit));
  assert_irq_needs_ae_R7: assert property (@(posedge clk) disable iff (rst)
    !irq_n |-> $past(af && ae));
  assert_batt_gate_R8: assert property (@(posedge clk) disable iff (rst)
    (on_battery && !abe) |=> irq_n);
  assert_read_clear_R9: assert property (@(posedge clk) disable iff (rst)
    (rd_ctrl && !hit) |=> !af);
  assert_pwrup_clear_R10: assert property (@(posedge clk) disable iff (rst)
    power_up |=> (!ae && !abe));
  assert_set_wins_R11: assert property (@(posedge clk) disable iff (rst)
    (rd_ctrl && hit) |=> af);
endmodule

// File: rtl/tod_alarm.sv
module tod_alarm
  import tod_alarm_pkg::*;
#(
  parameter int unsigned ADDR_W = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              tick,
  input  logic [7:0]        cur_sec,
  input  logic [7:0]        cur_min,
  input  logic [7:0]        cur_hour,
  input  logic [7:0]        cur_date,
  input  logic              on_battery,
  input  logic              power_up,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [7:0]        bus_wdata,
  output logic [7:0]        bus_rdata,
  output logic              irq_n
);
  localparam logic [ADDR_W-1:0] CTRL_ADDR = ADDR_W'(OFS_CTRL);

  field_vec_t        alarm_bytes;
  field_vec_t        live;
  logic              hit, ae, abe, af;
  logic              rd_ctrl, wr_ctrl;
  logic [BYTE_W-1:0] rd_mux;

  always_comb begin
    live[0] = cur_sec;
    live[1] = cur_min;
    live[2] = cur_hour;
    live[3] = cur_date;
  end

  always_comb begin
    rd_ctrl = bus_rd && bus_addr == CTRL_ADDR;
    wr_ctrl = bus_wr && bus_addr == CTRL_ADDR;
  end

  tod_alarm_regs #(.ADDR_W(ADDR_W)) u_regs (
    .clk(clk), .rst(rst), .wr(bus_wr), .addr(bus_addr),
    .wdata(bus_wdata), .alarm_bytes(alarm_bytes)
  );

  tod_alarm_match u_match (
    .tick(tick), .alarm_bytes(alarm_bytes), .live(live), .hit(hit)
  );

  tod_alarm_flag u_flag (
    .clk(clk), .rst(rst), .hit(hit), .rd_ctrl(rd_ctrl), .wr_ctrl(wr_ctrl),
    .wdata_ae(bus_wdata[AE_BIT]), .wdata_abe(bus_wdata[ABE_BIT]),
    .power_up(power_up), .on_battery(on_battery),
    .ae(ae), .abe(abe), .af(af), .irq_n(irq_n)
  );

  always_comb begin
    rd_mux = '0;
    for (int i = 0; i < NUM_FIELDS; i++) begin
      if (bus_addr == ADDR_W'(OFS_FIRST + i)) rd_mux = alarm_bytes[i];
    end
    if (bus_addr == CTRL_ADDR) begin
      rd_mux[AE_BIT]  = ae;
      rd_mux[ABE_BIT] = abe;
      rd_mux[AF_BIT]  = af;
    end
  end

  always_ff @(posedge clk) begin
    if (rst)         bus_rdata <= '0;
    else if (bus_rd) bus_rdata <= rd_mux;
  end

  assert_rdata_hold_R2: assert property (@(posedge clk) disable iff (rst)
    !bus_rd |=> $stable(bus_rdata));
endmodule

// File: tb/tod_alarm_tb.sv
module tod_alarm_tb;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       tick = 1'b0, on_battery = 1'b0, power_up = 1'b0;
  logic [7:0] cur_sec = '0, cur_min = '0, cur_hour = '0, cur_date = '0;
  logic       bus_wr = 1'b0, bus_rd = 1'b0;
  logic [2:0] bus_addr = '0;
  logic [7:0] bus_wdata = '0;
  logic [7:0] bus_rdata;
  logic       irq_n;

  int checks = 0, failures = 0;
  bit done = 1'b0;

  logic [7:0] al [4];
  logic       ae_m, abe_m, af_m;

  always #2 clk = ~clk;

  tod_alarm u_dut (
    .clk(clk), .rst(rst), .tick(tick), .cur_sec(cur_sec), .cur_min(cur_min),
    .cur_hour(cur_hour), .cur_date(cur_date), .on_battery(on_battery),
    .power_up(power_up), .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq_n(irq_n)
  );

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%02h expected=%02h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] bcd(input int n);
    return {4'(n / 10), 4'(n % 10)};
  endfunction

  function automatic logic model_hit(input logic [7:0] s, m, h, d);
    logic [7:0] lv [4];
    logic ok = 1'b1;
    lv[0] = s; lv[1] = m; lv[2] = h; lv[3] = d;
    for (int i = 0; i < 4; i++)
      if (!al[i][7] && {1'b0, al[i][6:0]} != lv[i]) ok = 1'b0;
    return ok;
  endfunction

  function automatic logic model_irq_n();
    return !(af_m && ae_m && (!on_battery || abe_m));
  endfunction

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0;
    if (a >= 2 && a <= 5) al[a - 2] = d;
    if (a == 6) begin ae_m = d[7]; abe_m = d[6]; end
  endtask

  task automatic rd(input logic [2:0] a, output logic [7:0] d);
    @(negedge clk);
    bus_rd = 1'b1; bus_addr = a;
    @(negedge clk);
    bus_rd = 1'b0;
    d = bus_rdata;
    if (a == 6) af_m = 1'b0;
  endtask

  task automatic do_tick(input logic [7:0] s, m, h, d);
    @(negedge clk);
    cur_sec = s; cur_min = m; cur_hour = h; cur_date = d; tick = 1'b1;
    @(negedge clk);
    tick = 1'b0;
    if (model_hit(s, m, h, d)) af_m = 1'b1;
  endtask

  function automatic logic [7:0] ctrl_exp();
    return {ae_m, abe_m, 5'b0, af_m};
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    logic [7:0] r;
    void'($urandom(32'd20240611));
    for (int i = 0; i < 4; i++) al[i] = '0;
    ae_m = 0; abe_m = 0; af_m = 0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    // R1 reset state
    chk("R1 irq_n", {7'b0, irq_n}, 8'h01);
    chk("R1 rdata", bus_rdata, 8'h00);
    rd(3'd6, r); chk("R1 ctrl", r, 8'h00);

    // R2 register access and unmapped offsets
    wr(3'd2, 8'h45); wr(3'd3, 8'h30); wr(3'd4, 8'h12); wr(3'd5, 8'h25);
    rd(3'd2, r); chk("R2 sec", r, 8'h45);
    rd(3'd3, r); chk("R2 min", r, 8'h30);
    rd(3'd4, r); chk("R2 hour", r, 8'h12);
    rd(3'd5, r); chk("R2 date", r, 8'h25);
    rd(3'd7, r); chk("R2 unmapped7", r, 8'h00);
    rd(3'd0, r); chk("R2 unmapped0", r, 8'h00);

    // R5 no tick, no flag
    @(negedge clk);
    cur_sec = 8'h45; cur_min = 8'h30; cur_hour = 8'h12; cur_date = 8'h25;
    repeat (4) @(negedge clk);
    rd(3'd6, r); chk("R5 no tick", r, 8'h00);

    // R3 mismatch then exact match; R6 flag not writable
    do_tick(8'h45, 8'h30, 8'h12, 8'h24);
    rd(3'd6, r); chk("R3 mismatch", r, 8'h00);
    wr(3'd6, 8'h01);
    rd(3'd6, r); chk("R6 flag write ignored", r, 8'h00);
    do_tick(8'h45, 8'h30, 8'h12, 8'h25);
    rd(3'd6, r); chk("R3 exact match", r, 8'h01);

    // R7 exact latency under main power
    wr(3'd6, 8'h80);
    chk("R6 ctrl readback pre", {7'b0, irq_n}, 8'h01);
    do_tick(8'h45, 8'h30, 8'h12, 8'h25);
    chk("R7 irq one edge late", {7'b0, irq_n}, 8'h01);
    @(negedge clk);
    chk("R7 irq low", {7'b0, irq_n}, 8'h00);
    // R9 read clears and releases
    rd(3'd6, r); chk("R9 read value", r, 8'h81);
    @(negedge clk);
    chk("R9 irq released", {7'b0, irq_n}, 8'h01);

    // R4 masks: daily repeat, then all masked
    wr(3'd5, 8'h80);
    do_tick(8'h45, 8'h30, 8'h12, 8'h03);
    rd(3'd6, r); chk("R4 daily", r, 8'h81);
    do_tick(8'h46, 8'h30, 8'h12, 8'h03);
    rd(3'd6, r); chk("R4 daily miss", r, 8'h80);
    wr(3'd2, 8'h80); wr(3'd3, 8'h80); wr(3'd4, 8'h80);
    do_tick(8'h07, 8'h11, 8'h22, 8'h19);
    rd(3'd6, r); chk("R4 every second", r, 8'h81);

    // R8 battery gating
    @(negedge clk); on_battery = 1'b1;
    do_tick(8'h01, 8'h02, 8'h03, 8'h04);
    @(negedge clk);
    chk("R8 AE only on battery", {7'b0, irq_n}, 8'h01);
    wr(3'd6, 8'hC0);
    @(negedge clk);
    chk("R8 AE+ABE on battery", {7'b0, irq_n}, 8'h00);
    rd(3'd6, r); chk("R8 ctrl", r, 8'hC1);
    @(negedge clk); on_battery = 1'b0;

    // R11 matching tick and flag read in the same cycle
    @(negedge clk);
    tick = 1'b1; bus_rd = 1'b1; bus_addr = 3'd6;
    @(negedge clk);
    tick = 1'b0; bus_rd = 1'b0;
    chk("R11 old value", bus_rdata, 8'hC0);
    af_m = 1'b1;
    rd(3'd6, r); chk("R11 set wins", r, 8'hC1);

    // R10 power-up with matching tick and colliding write
    @(negedge clk);
    power_up = 1'b1; tick = 1'b1; bus_wr = 1'b1; bus_addr = 3'd6; bus_wdata = 8'hC0;
    @(negedge clk);
    power_up = 1'b0; tick = 1'b0; bus_wr = 1'b0;
    ae_m = 0; abe_m = 0; af_m = 1;
    @(negedge clk);
    chk("R10 irq stays high", {7'b0, irq_n}, 8'h01);
    rd(3'd6, r); chk("R10 enables cleared, flag kept", r, 8'h01);

    // Random mix
    for (int it = 0; it < 300; it++) begin
      logic [7:0] cs, cm, ch, cd;
      if ($urandom % 4 == 0) begin
        wr(3'd2, {1'($urandom % 2), bcd($urandom % 60)});
        wr(3'd3, {1'($urandom % 2), bcd($urandom % 60)});
        wr(3'd4, {1'($urandom % 2), bcd($urandom % 24)});
        wr(3'd5, {1'($urandom % 2), bcd(1 + $urandom % 31)});
      end
      if ($urandom % 3 == 0) wr(3'd6, {2'($urandom), 6'($urandom)});
      @(negedge clk); on_battery = 1'($urandom % 2);
      cs = ($urandom % 2) ? {1'b0, al[0][6:0]} : bcd($urandom % 60);
      cm = ($urandom % 2) ? {1'b0, al[1][6:0]} : bcd($urandom % 60);
      ch = ($urandom % 2) ? {1'b0, al[2][6:0]} : bcd($urandom % 24);
      cd = ($urandom % 2) ? {1'b0, al[3][6:0]} : bcd(1 + $urandom % 31);
      do_tick(cs, cm, ch, cd);
      @(negedge clk);
      chk("R7 R8 random irq", {7'b0, irq_n}, {7'b0, model_irq_n()});
      if ($urandom % 2) begin
        logic [7:0] e;
        e = ctrl_exp();
        rd(3'd6, r); chk("R3 R9 random flag", r, e);
        @(negedge clk);
        chk("R9 random release", {7'b0, irq_n}, 8'h01);
      end
    end

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule